// File: doc/BRIEF.md
# Power-Domain Switch Sequencer

This block controls one switchable power domain. Software programs a 32-bit control word that holds a collapse request, a hardware-control select, a sequencer bypass and three 4-bit wait exponents. The controller then moves the domain between powered and collapsed states. On the way up it closes a small group of head switches, then the remaining switches, then enables the domain clocks. On the way down it gates the clocks and then opens all switches. Each step lasts 2^n reference-clock cycles, where n comes from its own field.

Every sequence begins with a fixed start-up window. During that window the outputs and the status flags still show the previous state. When hardware control is selected, an external collapse request drives the sequence and the software bit is ignored. Selecting hardware control also forces one power-down/power-up cycle. A bypass mode drives the switch and clock enables straight from the software bit.

Top module: `pdc_ctrl`

## Requirements
- R1: After reset the domain is on: `sw_few_en`, `sw_rest_en` and `dom_clk_en` are 1. The control word reads `0x8000_0000` with the reset wait exponents merged in at bits 23:20 (rest), 19:16 (few) and 15:12 (clock-off). The status word reads `0x0001_0000`.
- R2: The control word is at byte address 0. Its fields are: bit 0 collapse request (1 = down), bit 1 hardware control, bit 2 bypass, and the wait exponents at bits 23:20, 19:16 and 15:12. Bit 31 is a read-only "fully on" flag. All other bits read 0. Writes to any address other than 0 change nothing, and reads from any address other than 0 and 4 return 0.
- R3: The status word is at byte address 4. Bit 16 is set when power-up is complete and bit 15 is set when power-down is complete. The two bits are never both set.
- R4: After a new power request, the enables and both status flags keep their old values for START_CYC cycles.
- R5: A collapse request gates `dom_clk_en` START_CYC+1 cycles after the request. Both switch enables drop 2^clock-off cycles later, and the power-down flag sets in that same cycle.
- R6: A power-up request raises `sw_few_en` START_CYC+1 cycles after the request. `sw_rest_en` rises 2^few cycles later. `dom_clk_en` and the power-up flag rise 2^rest cycles after that.
- R7: A request that arrives during a sequence does not cut the sequence short. It is served once the running sequence completes, starting with a new start-up window.
- R8: With hardware control selected, `hw_collapse_req` (1 = down) drives the sequence with the same timing, and bit 0 has no effect.
- R9: Writing 1 to the hardware-control bit while it is 0 makes the domain run a full power-down and then a power-up before it reports on, provided the hardware request asks for power.
- R10: With bypass set, all three enables equal the inverse of bit 0 in the cycle after the write, with no waits. The status flags follow one cycle later.
- R11: Once the start-up window has passed and until the sequence completes, both status flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also counts all waits |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hw_collapse_req | input | 1 | External request, 1 = collapse, used under hardware control |
| sw_few_en | output | 1 | Closes the first, small group of power switches |
| sw_rest_en | output | 1 | Closes the remaining power switches |
| dom_clk_en | output | 1 | Enables the domain clocks |

## Verification
The bench keeps START_CYC at 8 and sets small reset exponents (rest 1, few 2, clock-off 3). This keeps every sequence under about thirty cycles. The bench can then sweep all 64 combinations of the exponents 0 to 3 through a full down-and-up pass. It measures the cycle of every enable edge and flag change against arithmetic expectations, including the one-cycle steps where an exponent is 0. The short windows also make it cheap to land a write in the middle of a clock-off wait, to switch hardware control on and off, and to exercise bypass and the full register map.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
  localparam int unsigned WAIT_W = 4;
  localparam int unsigned CNT_W  = 1 << WAIT_W;

  localparam int unsigned CB_COLLAPSE = 0;
  localparam int unsigned CB_HWCTL    = 1;
  localparam int unsigned CB_BYPASS   = 2;
  localparam int unsigned CB_CDIS_LSB = 12;
  localparam int unsigned CB_FEW_LSB  = 16;
  localparam int unsigned CB_REST_LSB = 20;
  localparam int unsigned CB_PWR_ON   = 31;
  localparam int unsigned SB_DN_DONE  = 15;
  localparam int unsigned SB_UP_DONE  = 16;

  typedef enum logic [2:0] {
    ST_ON       = 3'd0,
    ST_DN_START = 3'd1,
    ST_CLK_OFF  = 3'd2,
    ST_OFF      = 3'd3,
    ST_UP_START = 3'd4,
    ST_FEW      = 3'd5,
    ST_REST     = 3'd6
  } pdc_state_e;

  // load value giving a stay of exactly 2^n cycles
  function automatic logic [CNT_W-1:0] wait_load(input logic [WAIT_W-1:0] n);
    return (CNT_W'(1) << n) - CNT_W'(1);
  endfunction
endpackage

// File: rtl/pdc_rst_sync.sv
`timescale 1ns/1ps
module pdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdc_regs.sv
`timescale 1ns/1ps
module pdc_regs import pdc_pkg::*; #(
  parameter logic [WAIT_W-1:0] RST_REST = 4'd2,
  parameter logic [WAIT_W-1:0] RST_FEW  = 4'd8,
  parameter logic [WAIT_W-1:0] RST_CDIS = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic              collapse,
  output logic              hw_ctl,
  output logic              bypass,
  output logic [WAIT_W-1:0] w_rest,
  output logic [WAIT_W-1:0] w_few,
  output logic [WAIT_W-1:0] w_cdis,
  output logic              arm_cycle
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:CB_REST_LSB+WAIT_W], wdata[CB_CDIS_LSB-1:CB_BYPASS+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collapse <= 1'b0;
      hw_ctl   <= 1'b0;
      bypass   <= 1'b0;
      w_rest   <= RST_REST;
      w_few    <= RST_FEW;
      w_cdis   <= RST_CDIS;
    end else if (wr_en) begin
      collapse <= wdata[CB_COLLAPSE];
      hw_ctl   <= wdata[CB_HWCTL];
      bypass   <= wdata[CB_BYPASS];
      w_rest   <= wdata[CB_REST_LSB +: WAIT_W];
      w_few    <= wdata[CB_FEW_LSB  +: WAIT_W];
      w_cdis   <= wdata[CB_CDIS_LSB +: WAIT_W];
    end
  end

  // turning hardware control on asks for one down/up cycle
  assign arm_cycle = wr_en & wdata[CB_HWCTL] & ~hw_ctl;
endmodule

// File: rtl/pdc_seq.sv
`timescale 1ns/1ps
module pdc_seq import pdc_pkg::*; #(
  parameter int unsigned START_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eff_collapse,
  input  logic              arm_cycle,
  input  logic              bypass,
  input  logic              byp_collapse,
  input  logic [WAIT_W-1:0] w_rest,
  input  logic [WAIT_W-1:0] w_few,
  input  logic [WAIT_W-1:0] w_cdis,
  output logic              few_en,
  output logic              rest_en,
  output logic              clk_en,
  output logic              up_done,
  output logic              dn_done
);
  localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(START_CYC - 1);

  pdc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cycle_q, cycle_d;
  logic             up_q, up_d, dn_q, dn_d;
  logic             expired;

  assign expired = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = expired ? cnt_q : cnt_q - CNT_W'(1);
    cycle_d = cycle_q | arm_cycle;
    up_d    = up_q;
    dn_d    = dn_q;
    if (bypass) begin
      state_d = byp_collapse ? ST_OFF : ST_ON;
      cnt_d   = '0;
      cycle_d = 1'b0;
      up_d    = ~byp_collapse;
      dn_d    = byp_collapse;
    end else begin
      unique case (state_q)
        ST_ON: if (eff_collapse || cycle_q) begin
          state_d = ST_DN_START;
          cnt_d   = START_LOAD;
          cycle_d = arm_cycle;
        end
        ST_DN_START: if (expired) begin
          state_d = ST_CLK_OFF;
          cnt_d   = wait_load(w_cdis);
          up_d    = 1'b0;
          dn_d    = 1'b0;
        end
        ST_CLK_OFF: if (expired) begin
          state_d = ST_OFF;
          dn_d    = 1'b1;
        end
        ST_OFF: if (!eff_collapse) begin
          state_d = ST_UP_START;
          cnt_d   = START_LOAD;
          cycle_d = arm_cycle;
        end
        ST_UP_START: if (expired) begin
          state_d = ST_FEW;
          cnt_d   = wait_load(w_few);
          up_d    = 1'b0;
          dn_d    = 1'b0;
        end
        ST_FEW: if (expired) begin
          state_d = ST_REST;
          cnt_d   = wait_load(w_rest);
        end
        ST_REST: if (expired) begin
          state_d = ST_ON;
          up_d    = 1'b1;
        end
        default: state_d = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ON;
      cnt_q   <= '0;
      cycle_q <= 1'b0;
      up_q    <= 1'b1;
      dn_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cycle_q <= cycle_d;
      up_q    <= up_d;
      dn_q    <= dn_d;
    end
  end

  logic [2:0] en_vec;
  always_comb begin
    if (bypass) en_vec = {3{~byp_collapse}};
    else begin
      unique case (state_q)
        ST_ON, ST_DN_START:  en_vec = 3'b111;
        ST_CLK_OFF, ST_REST: en_vec = 3'b110;
        ST_FEW:              en_vec = 3'b100;
        default:             en_vec = 3'b000;
      endcase
    end
  end

  assign {few_en, rest_en, clk_en} = en_vec;
  assign up_done = up_q;
  assign dn_done = dn_q;
endmodule

// File: rtl/pdc_ctrl.sv
`timescale 1ns/1ps
module pdc_ctrl import pdc_pkg::*; #(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       START_CYC = 8,
  parameter logic [WAIT_W-1:0] RST_REST  = 4'd2,
  parameter logic [WAIT_W-1:0] RST_FEW   = 4'd8,
  parameter logic [WAIT_W-1:0] RST_CDIS  = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hw_collapse_req,
  output logic              sw_few_en,
  output logic              sw_rest_en,
  output logic              dom_clk_en
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

  logic              rst_sync_n;
  logic              collapse, hw_ctl, bypass, arm_cycle, eff_collapse;
  logic [WAIT_W-1:0] w_rest, w_few, w_cdis;
  logic              up_done, dn_done;

  pdc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pdc_regs #(.RST_REST(RST_REST), .RST_FEW(RST_FEW), .RST_CDIS(RST_CDIS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_wr && (reg_addr == A_CTRL)), .wdata(reg_wdata),
    .collapse(collapse), .hw_ctl(hw_ctl), .bypass(bypass),
    .w_rest(w_rest), .w_few(w_few), .w_cdis(w_cdis), .arm_cycle(arm_cycle)
  );

  assign eff_collapse = hw_ctl ? hw_collapse_req : collapse;

  pdc_seq #(.START_CYC(START_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .eff_collapse(eff_collapse), .arm_cycle(arm_cycle),
    .bypass(bypass), .byp_collapse(collapse),
    .w_rest(w_rest), .w_few(w_few), .w_cdis(w_cdis),
    .few_en(sw_few_en), .rest_en(sw_rest_en), .clk_en(dom_clk_en),
    .up_done(up_done), .dn_done(dn_done)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[CB_PWR_ON]                = up_done;
      reg_rdata[CB_REST_LSB +: WAIT_W]    = w_rest;
      reg_rdata[CB_FEW_LSB  +: WAIT_W]    = w_few;
      reg_rdata[CB_CDIS_LSB +: WAIT_W]    = w_cdis;
      reg_rdata[CB_BYPASS]                = bypass;
      reg_rdata[CB_HWCTL]                 = hw_ctl;
      reg_rdata[CB_COLLAPSE]              = collapse;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[SB_UP_DONE] = up_done;
      reg_rdata[SB_DN_DONE] = dn_done;
    end
  end
endmodule

// File: rtl/pdc_ctrl_chk.sv
`timescale 1ns/1ps
module pdc_ctrl_chk import pdc_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       bypass,
  input logic       eff_collapse,
  input logic [2:0] st,
  input logic       few_en,
  input logic       rest_en,
  input logic       clk_en,
  input logic       up_done,
  input logic       dn_done
);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_done && dn_done));

  a_r4_dn_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == ST_ON && eff_collapse) |=>
      (bypass || (few_en && rest_en && clk_en && up_done)));

  a_r4_up_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st == ST_OFF && !eff_collapse) |=>
      (bypass || (!few_en && !rest_en && !clk_en && dn_done)));

  a_r5_clk_before_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_en) && !bypass) |-> (few_en && rest_en));

  a_r6_rest_before_clk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_en) && !bypass) |-> $past(rest_en));

  a_r6_few_before_rest: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rest_en) && !bypass) |-> $past(few_en));
endmodule

bind pdc_ctrl pdc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bypass(bypass), .eff_collapse(eff_collapse),
  .st(u_seq.state_q), .few_en(sw_few_en), .rest_en(sw_rest_en),
  .clk_en(dom_clk_en), .up_done(up_done), .dn_done(dn_done)
);

// File: tb/sim_pdc_ctrl.sv
`timescale 1ns/1ps
module sim_pdc_ctrl;
  localparam int S = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hw_req;
  logic        few, rest, cen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdc_ctrl #(.ADDR_W(4), .START_CYC(S), .RST_REST(4'd1), .RST_FEW(4'd2), .RST_CDIS(4'd3)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_collapse_req(hw_req),
    .sw_few_en(few), .sw_rest_en(rest), .dom_clk_en(cen)
  );

  int t_clkdn, t_swdn, t_swup, t_restup, t_clkup;
  logic fl_dn, fl_up;
  logic [1:0] fl0, fl_win, fl_tr;
  logic [2:0] en0, en_win;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // write lands at the next posedge; returns at the following negedge (t=0)
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd4;
    #1;
  endtask

  task automatic watch(input int limit, input int mid, input logic [31:0] mid_data);
    logic [2:0] pe;
    logic [2:0] e;
    t_clkdn = -1; t_swdn = -1; t_swup = -1; t_restup = -1; t_clkup = -1;
    fl_dn = 1'b0; fl_up = 1'b0; fl_win = 2'bxx; fl_tr = 2'bxx; en_win = 3'bxxx;
    en0 = {few, rest, cen}; fl0 = reg_rdata[16:15]; pe = en0;
    for (int t = 1; t <= limit; t++) begin
      if (t - 1 == mid) begin
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = mid_data;
      end
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 4'd4;
      #1;
      e = {few, rest, cen};
      if (pe[0] && !e[0] && t_clkdn < 0) t_clkdn = t;
      if (pe[2] && !e[2] && t_swdn < 0) begin t_swdn = t; fl_dn = reg_rdata[15]; end
      if (!pe[2] && e[2] && t_swup < 0) t_swup = t;
      if (!pe[1] && e[1] && t_restup < 0) t_restup = t;
      if (!pe[0] && e[0] && t_clkup < 0) begin t_clkup = t; fl_up = reg_rdata[16]; end
      if (t == S) begin en_win = e; fl_win = reg_rdata[16:15]; end
      if (t == S + 1) fl_tr = reg_rdata[16:15];
      pe = e;
    end
  endtask

  function automatic logic [31:0] ctl(input int r, input int f, input int c, input int bits);
    return 32'((r << 20) | (f << 16) | (c << 12) | bits);
  endfunction

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = '0; hw_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 ctrl", reg_rdata, 32'h8012_3000);
    chk("R1 enables", {few, rest, cen}, 3'b111);
    reg_addr = 4'd4; #1;
    chk("R1 status", reg_rdata, 32'h0001_0000);

    // R5/R6/R4/R11 sweep over all small exponents
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 4; f++)
        for (int r = 0; r < 4; r++) begin
          wr(4'd0, ctl(r, f, c, 1));
          watch(S + 1 + (1 << c) + 2, 1000, '0);
          chk("R5 clk gate time", t_clkdn, S + 1);
          chk("R5 switch open time", t_swdn, S + 1 + (1 << c));
          chk("R5 down flag", fl_dn, 1);
          chk("R4 down window enables", en_win, en0);
          chk("R4 down window flags", fl_win, fl0);
          chk("R11 down transit flags", fl_tr, 2'b00);
          wr(4'd0, ctl(r, f, c, 0));
          watch(S + 1 + (1 << f) + (1 << r) + 2, 1000, '0);
          chk("R6 few time", t_swup, S + 1);
          chk("R6 rest time", t_restup, S + 1 + (1 << f));
          chk("R6 clk time", t_clkup, S + 1 + (1 << f) + (1 << r));
          chk("R6 up flag", fl_up, 1);
          chk("R4 up window enables", en_win, en0);
          chk("R4 up window flags", fl_win, fl0);
          chk("R11 up transit flags", fl_tr, 2'b00);
        end

    // R7 power-up request issued during the clock-off wait
    wr(4'd0, ctl(1, 1, 2, 1));
    watch(40, 10, ctl(1, 1, 2, 0));
    chk("R7 down completes", t_swdn, S + 1 + 4);
    chk("R7 up starts after", t_swup, S + 1 + 4 + S + 1);
    chk("R7 up completes", t_clkup, S + 1 + 4 + S + 1 + 4);
    chk("R7 up flag", fl_up, 1);

    // R9 selecting hardware control forces a down/up cycle
    wr(4'd0, ctl(1, 1, 2, 2));
    watch(40, 1000, '0);
    chk("R9 clk gated", t_clkdn, S + 1);
    chk("R9 switches open", t_swdn, S + 1 + 4);
    chk("R9 switches close", t_swup, S + 1 + 4 + S + 1);
    chk("R9 back on", t_clkup, S + 1 + 4 + S + 1 + 4);

    // R8 software bit ignored under hardware control
    wr(4'd0, ctl(1, 1, 2, 3));
    watch(30, 1000, '0);
    chk("R8 bit0 ignored", t_clkdn, -1);
    chk("R8 still on", {few, rest, cen}, 3'b111);
    hw_req = 1'b1;
    watch(30, 1000, '0);
    chk("R8 hw down clk", t_clkdn, S + 1);
    chk("R8 hw down switch", t_swdn, S + 1 + 4);
    hw_req = 1'b0;
    watch(30, 1000, '0);
    chk("R8 hw up few", t_swup, S + 1);
    chk("R8 hw up clk", t_clkup, S + 1 + 4);
    wr(4'd0, ctl(1, 1, 2, 0));
    watch(30, 1000, '0);
    chk("R8 release no change", t_clkdn, -1);

    // R10 bypass
    wr(4'd0, ctl(1, 1, 2, 5));
    chk("R10 bypass off enables", {few, rest, cen}, 3'b000);
    @(negedge clk); #1;
    chk("R10 bypass off status", reg_rdata, 32'h0000_8000);
    wr(4'd0, ctl(1, 1, 2, 4));
    chk("R10 bypass on enables", {few, rest, cen}, 3'b111);
    @(negedge clk); #1;
    chk("R10 bypass on status", reg_rdata, 32'h0001_0000);
    wr(4'd0, ctl(1, 1, 2, 0));
    watch(30, 1000, '0);
    chk("R10 bypass release no change", t_clkdn, -1);

    // R2/R3 register map
    wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_addr = 4'd0; #1;
    chk("R2 readback", reg_rdata, 32'h00FF_F007);
    reg_addr = 4'd4; #1;
    chk("R3 status off", reg_rdata, 32'h0000_8000);
    wr(4'd8, 32'h0000_0000);
    reg_addr = 4'd0; #1;
    chk("R2 other address write ignored", reg_rdata, 32'h00FF_F007);
    reg_addr = 4'd8; #1;
    chk("R2 other address reads zero", reg_rdata, 32'h0);
    wr(4'd0, 32'h0);
    watch(S + 6, 1000, '0);
    chk("R3 status on", reg_rdata, 32'h0001_0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule